// File: doc/BRIEF.md
# I2C Master Serial Clock Pacer

This block produces the serial clock for an I2C-style bus master. The line is open-drain, so the block only asserts a drive-low enable. It reads the line back through a synchroniser and paces every low and high phase with a reloadable down-counter. The counter steps once every `TICK_DIV` system clocks. When the block lets the line go, the counter waits, frozen, until the line is actually seen high. Only then does it reload and time the high phase. A slave that stretches the clock therefore still gets a full high period after it lets go.

The host starts a sequence by writing one command bit: start, repeated start, stop, byte receive or byte transmit. Commands are not queued. A command write that arrives while a sequence runs is dropped. The block also holds a one-byte data buffer. A host write to the buffer while a sequence runs is refused, and a sticky write-collision flag records it. Data shifting on SDA, address matching and SDA arbitration belong to other blocks.

Top module: `scl_pacer`

## Requirements
- R1: After reset the drive-low enable, busy, the collision flag and the done pulse are all 0, and the buffer reads 0.
- R2: Command bit encoding is bit 0 start, bit 1 repeated start, bit 2 stop, bit 3 byte receive, bit 4 byte transmit. When several bits are set, the lowest set bit wins. A write with no bit set starts nothing.
- R3: In a low phase the line is driven low for exactly TICK_DIV*N+1 cycles, where N is the reload value. The counter steps down once every TICK_DIV cycles and stops at zero. The line is released when the count reaches zero.
- R4: Once released, the counter is frozen until the line is seen high through a two-flop synchroniser. Only then does it reload N and time a TICK_DIV*N+1 cycle high phase. With no stretch and with any slave hold, the bus is high for TICK_DIV*N+4 cycles before it is driven low again.
- R5: Sequence shapes, where P = TICK_DIV*N+1 and W is the release wait (3 cycles after a low, 1 if the line was already high, longer while a slave holds). A start releases, waits, gives one high phase and then drives low (W+P cycles). A repeated start gives low, wait, high and ends driven low (2P+W). A stop gives the same three phases but ends released (2P+W). A byte gives PULSES_PER_BYTE such pulses and ends driven low.
- R6: Busy is high from the cycle after a command is taken until the sequence ends. In the cycle busy falls, the done output pulses high for exactly one cycle.
- R7: A command write made while busy is ignored. It is not queued and does not alter the running sequence.
- R8: A buffer write while busy leaves the buffer unchanged and sets the collision flag. A buffer write while idle updates the buffer.
- R9: The collision flag stays set until the clear strobe. A collision in the same cycle as the clear leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reload_i | input | CNT_W | Count reload value N |
| scl_line_i | input | 1 | Raw level read back from the SCL line |
| cmd_wr_i | input | 1 | Command write strobe |
| cmd_bits_i | input | 5 | Command request bits |
| buf_wr_i | input | 1 | Data buffer write strobe |
| buf_data_i | input | DATA_W | Data for a buffer write |
| wcol_clr_i | input | 1 | Clear strobe for the collision flag |
| scl_drive_low_o | output | 1 | Drive-low enable for the open-drain SCL pad |
| busy_o | output | 1 | A sequence is in progress |
| wcol_o | output | 1 | Sticky write-collision flag |
| seq_done_o | output | 1 | One-cycle pulse at the end of a sequence |
| buf_data_o | output | DATA_W | Current data buffer contents |

## Verification
The bench builds the block with its default parameters: TICK_DIV=2, PULSES_PER_BYTE=9, SYNC_STAGES=2, 8-bit counter and buffer. It varies the reload value across 0, 3 and 5 through the port. The fixed two-stage synchroniser makes the release wait an exact, predictable number of cycles. Every low run, bus-high run and sequence length can therefore be predicted to the cycle. A modelled slave that holds the line 20 cycles past each release brings the frozen counter, the deferred reload and the full high time within reach.

// File: rtl/scl_pacer_pkg.sv
package scl_pacer_pkg;

    localparam int CMD_BITS = 5;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_LOW,
        PH_WAIT,
        PH_HIGH
    } phase_e;

    typedef enum logic [2:0] {
        SQ_NONE,
        SQ_START,
        SQ_RESTART,
        SQ_STOP,
        SQ_RECV,
        SQ_XMIT
    } seq_e;

    // Lowest set request bit wins (R2)
    function automatic seq_e pick_seq(input logic [CMD_BITS-1:0] bits);
        seq_e s;
        if (bits[0])      s = SQ_START;
        else if (bits[1]) s = SQ_RESTART;
        else if (bits[2]) s = SQ_STOP;
        else if (bits[3]) s = SQ_RECV;
        else if (bits[4]) s = SQ_XMIT;
        else              s = SQ_NONE;
        return s;
    endfunction

endpackage

// File: rtl/scl_line_sync.sv
module scl_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic seen_o
);

    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], line_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= sh_d;
    end

    assign seen_o = sh_q[STAGES-1];

endmodule

// File: rtl/scl_tick_div.sv
module scl_tick_div #(
    parameter int DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    output logic tick_o
);

    localparam int TW = (DIV > 1) ? $clog2(DIV) : 1;

    generate
        if (DIV > 1) begin : g_div
            logic [TW-1:0] ph_d, ph_q;

            always_comb begin
                if (restart_i)                     ph_d = '0;
                else if (ph_q == TW'(DIV - 1))     ph_d = '0;
                else                               ph_d = ph_q + TW'(1);
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) ph_q <= '0;
                else        ph_q <= ph_d;
            end

            assign tick_o = (ph_q == TW'(DIV - 1));
        end else begin : g_every
            assign tick_o = 1'b1;
        end
    endgenerate

endmodule

// File: rtl/scl_baud_cnt.sv
module scl_baud_cnt #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             run_i,
    input  logic             tick_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             zero_o
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)
            cnt_d = load_val_i;
        else if (run_i && tick_i && (cnt_q != '0))
            cnt_d = cnt_q - CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o  = cnt_q;
    assign zero_o = (cnt_q == '0);

    AST_CNT_PARKS_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && (cnt_q == '0)) |=> (cnt_q == '0)); // R3

endmodule

// File: rtl/scl_host_port.sv
module scl_host_port #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy_i,
    input  logic              buf_wr_i,
    input  logic [DATA_W-1:0] buf_data_i,
    input  logic              wcol_clr_i,
    output logic [DATA_W-1:0] buf_data_o,
    output logic              wcol_o
);

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              wcol;
    } host_s;

    host_s d, q;

    always_comb begin
        d = q;
        if (buf_wr_i && busy_i)
            d.wcol = 1'b1;
        else if (wcol_clr_i)
            d.wcol = 1'b0;
        if (buf_wr_i && !busy_i)
            d.data = buf_data_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign buf_data_o = q.data;
    assign wcol_o     = q.wcol;

    AST_BUF_KEPT_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && buf_wr_i) |=> ($stable(q.data) && q.wcol)); // R8
    AST_WCOL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (q.wcol && !wcol_clr_i) |=> q.wcol); // R9

endmodule

// File: rtl/scl_seq_fsm.sv
module scl_seq_fsm
    import scl_pacer_pkg::*;
#(
    parameter int PULSES = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_wr_i,
    input  logic [CMD_BITS-1:0] cmd_bits_i,
    input  logic                scl_seen_i,
    input  logic                cnt_zero_i,
    output logic                load_o,
    output logic                run_o,
    output logic                drive_low_o,
    output logic                busy_o,
    output logic                done_o,
    output phase_e              phase_o
);

    localparam int PW = $clog2(PULSES + 1);

    typedef struct packed {
        phase_e        ph;
        seq_e          sq;
        logic [PW-1:0] left;
        logic          park;
        logic          drive;
        logic          done;
    } fsm_s;

    fsm_s d, q;
    seq_e pick;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        pick   = pick_seq(cmd_bits_i);
        unique case (q.ph)
            PH_IDLE: begin
                if (cmd_wr_i && (pick != SQ_NONE)) begin
                    d.sq   = pick;
                    d.left = ((pick == SQ_RECV) || (pick == SQ_XMIT)) ? PW'(PULSES) : PW'(1);
                    d.ph   = (pick == SQ_START) ? PH_WAIT : PH_LOW;
                end
            end
            PH_LOW: begin
                if (cnt_zero_i) d.ph = PH_WAIT;
            end
            PH_WAIT: begin
                if (scl_seen_i) d.ph = PH_HIGH;
            end
            PH_HIGH: begin
                if (cnt_zero_i) begin
                    if (q.left > PW'(1)) begin
                        d.left = q.left - PW'(1);
                        d.ph   = PH_LOW;
                    end else begin
                        d.ph   = PH_IDLE;
                        d.done = 1'b1;
                        d.park = (q.sq != SQ_STOP);
                        d.sq   = SQ_NONE;
                    end
                end
            end
            default: d.ph = PH_IDLE;
        endcase
        d.drive = (d.ph == PH_LOW) || ((d.ph == PH_IDLE) && d.park);
        load_o  = (q.ph == PH_IDLE) ||
                  ((d.ph != q.ph) && ((d.ph == PH_LOW) || (d.ph == PH_HIGH)));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.ph    <= PH_IDLE;
            q.sq    <= SQ_NONE;
            q.left  <= '0;
            q.park  <= 1'b0;
            q.drive <= 1'b0;
            q.done  <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign run_o       = (q.ph == PH_LOW) || (q.ph == PH_HIGH);
    assign drive_low_o = q.drive;
    assign busy_o      = (q.ph != PH_IDLE);
    assign done_o      = q.done;
    assign phase_o     = q.ph;

    AST_LOW_HOLDS_TILL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.ph == PH_LOW) && !cnt_zero_i) |=> (q.ph == PH_LOW)); // R3
    AST_WAIT_NEEDS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.ph == PH_WAIT) && !scl_seen_i) |=> (q.ph == PH_WAIT)); // R4
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |=> !q.done); // R6
    AST_IDLE_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.ph == PH_IDLE) && !cmd_wr_i) |=> (q.ph == PH_IDLE)); // R2

endmodule

// File: rtl/scl_pacer.sv
module scl_pacer
    import scl_pacer_pkg::*;
#(
    parameter int CNT_W           = 8,
    parameter int DATA_W          = 8,
    parameter int TICK_DIV        = 2,
    parameter int PULSES_PER_BYTE = 9,
    parameter int SYNC_STAGES     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  reload_i,
    input  logic              scl_line_i,
    input  logic              cmd_wr_i,
    input  logic [4:0]        cmd_bits_i,
    input  logic              buf_wr_i,
    input  logic [DATA_W-1:0] buf_data_i,
    input  logic              wcol_clr_i,
    output logic              scl_drive_low_o,
    output logic              busy_o,
    output logic              wcol_o,
    output logic              seq_done_o,
    output logic [DATA_W-1:0] buf_data_o
);

    logic             scl_seen;
    logic             tick;
    logic             load;
    logic             run;
    logic             cnt_zero;
    logic [CNT_W-1:0] cnt;
    phase_e           phase;

    scl_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .line_i (scl_line_i),
        .seen_o (scl_seen)
    );

    scl_tick_div #(.DIV(TICK_DIV)) u_tick (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (load),
        .tick_o    (tick)
    );

    scl_baud_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load),
        .load_val_i (reload_i),
        .run_i      (run),
        .tick_i     (tick),
        .cnt_o      (cnt),
        .zero_o     (cnt_zero)
    );

    scl_seq_fsm #(.PULSES(PULSES_PER_BYTE)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_wr_i    (cmd_wr_i),
        .cmd_bits_i  (cmd_bits_i),
        .scl_seen_i  (scl_seen),
        .cnt_zero_i  (cnt_zero),
        .load_o      (load),
        .run_o       (run),
        .drive_low_o (scl_drive_low_o),
        .busy_o      (busy_o),
        .done_o      (seq_done_o),
        .phase_o     (phase)
    );

    scl_host_port #(.DATA_W(DATA_W)) u_host (
        .clk        (clk),
        .rst_n      (rst_n),
        .busy_i     (busy_o),
        .buf_wr_i   (buf_wr_i),
        .buf_data_i (buf_data_i),
        .wcol_clr_i (wcol_clr_i),
        .buf_data_o (buf_data_o),
        .wcol_o     (wcol_o)
    );

    AST_CNT_FROZEN_IN_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_WAIT) |=> ((phase != PH_WAIT) || $stable(cnt))); // R4
    AST_RELOAD_ON_SIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase == PH_WAIT) && scl_seen) |=> (cnt == $past(reload_i))); // R4
    AST_RELEASED_OFF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase == PH_WAIT) || (phase == PH_HIGH)) |-> !scl_drive_low_o); // R5

endmodule

// File: tb/sim_scl_pacer.sv
module sim_scl_pacer;

    localparam int TICK   = 2;
    localparam int PULSES = 9;

    logic       clk;
    logic       rst_n;
    logic       cmd_wr;
    logic [4:0] cmd_bits;
    logic       buf_wr;
    logic [7:0] buf_din;
    logic       wcol_clr;
    logic       drv;
    logic       busy;
    logic       wcol;
    logic       done;
    logic [7:0] buf_q;
    logic [7:0] reload;
    logic       bus;

    int n_rel      = 3;
    int hold_left  = 0;
    int hold_h     = 0;
    bit stretch_en = 0;
    bit parked     = 0;
    bit mon_on     = 0;
    int checks     = 0;
    int failures   = 0;
    int done_cnt   = 0;

    int exp_lat[$];
    bit exp_drv[$];

    assign reload = n_rel[7:0];
    assign bus    = !drv && (hold_left == 0);

    scl_pacer #(
        .CNT_W(8), .DATA_W(8), .TICK_DIV(TICK),
        .PULSES_PER_BYTE(PULSES), .SYNC_STAGES(2)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .reload_i(reload), .scl_line_i(bus),
        .cmd_wr_i(cmd_wr), .cmd_bits_i(cmd_bits), .buf_wr_i(buf_wr),
        .buf_data_i(buf_din), .wcol_clr_i(wcol_clr),
        .scl_drive_low_o(drv), .busy_o(busy), .wcol_o(wcol),
        .seq_done_o(done), .buf_data_o(buf_q)
    );

    initial begin
        clk = 1'b0;
        forever #5 clk = ~clk;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Slave model: holds the line low hold_h cycles past each release when enabled
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (stretch_en && drv) hold_left = hold_h;
            else if (hold_left > 0) hold_left--;
        end
    end

    function automatic int lat_of(input int kind);
        int p, w;
        p = TICK * n_rel + 1;
        w = stretch_en ? hold_h + 2 : 3;
        case (kind)
            0:       return (parked ? w : 1) + p;
            1, 2:    return 2 * p + w;
            default: return PULSES * (2 * p + w);
        endcase
    endfunction

    // Driver: pushes expected items and pulses a command write
    task automatic issue(input logic [4:0] bits, input int kind);
        exp_lat.push_back(lat_of(kind));
        exp_drv.push_back(kind != 2);
        @(negedge clk);
        cmd_wr = 1'b1; cmd_bits = bits;
        @(negedge clk);
        cmd_wr = 1'b0; cmd_bits = '0;
    endtask

    task automatic wait_done(input int kind);
        int target;
        target = done_cnt + 1;
        while (done_cnt < target) @(negedge clk);
        parked = (kind != 2);
    endtask

    task automatic do_seq(input logic [4:0] bits, input int kind);
        issue(bits, kind);
        wait_done(kind);
    endtask

    task automatic host_pulse(input bit wr, input logic [7:0] v, input bit clr);
        @(negedge clk);
        buf_wr = wr; buf_din = v; wcol_clr = clr;
        @(negedge clk);
        buf_wr = 1'b0; wcol_clr = 1'b0;
    endtask

    // Monitor: pops expected items on each done pulse, measures low and high runs
    int  busy_run = 0;
    int  lrun = 0, hrun = 0;
    bit  lrun_ok = 0, hrun_ok = 0;
    bit  prev_drv = 0, prev_bus = 1;

    always @(negedge clk) begin
        if (mon_on) begin
            if (busy) busy_run++;
            if (done) begin
                if (exp_lat.size() == 0) begin
                    chk(1'b0, "R7 unexpected sequence end", busy_run, 0);
                end else begin
                    int el;
                    bit ed;
                    el = exp_lat.pop_front();
                    ed = exp_drv.pop_front();
                    chk(busy_run == el, "R5 R6 sequence length", busy_run, el);
                    chk(drv == ed, "R5 final line drive", int'(drv), int'(ed));
                    chk(!busy, "R6 busy low with done", int'(busy), 0);
                end
                busy_run = 0;
                done_cnt++;
            end
            if (drv && !prev_drv) begin
                lrun = 1; lrun_ok = busy;
            end else if (drv) begin
                lrun++;
            end else if (prev_drv && lrun_ok && busy) begin
                chk(lrun == TICK * n_rel + 1, "R3 low phase width", lrun, TICK * n_rel + 1);
            end
            if (bus && !prev_bus) begin
                hrun = 1; hrun_ok = busy;
            end else if (bus) begin
                hrun++;
            end else if (prev_bus && hrun_ok && busy) begin
                chk(hrun == TICK * n_rel + 4, "R4 bus high width", hrun, TICK * n_rel + 4);
            end
            prev_drv = drv;
            prev_bus = bus;
        end
    end

    bit finished = 0;

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; cmd_wr = 1'b0; cmd_bits = '0;
        buf_wr = 1'b0; buf_din = '0; wcol_clr = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(drv == 1'b0,  "R1 drive after reset", int'(drv), 0);
        chk(busy == 1'b0, "R1 busy after reset", int'(busy), 0);
        chk(wcol == 1'b0, "R1 wcol after reset", int'(wcol), 0);
        chk(done == 1'b0, "R1 done after reset", int'(done), 0);
        chk(buf_q == 8'h00, "R1 buffer after reset", int'(buf_q), 0);
        mon_on = 1'b1;

        // R8 idle buffer write
        n_rel = 3;
        host_pulse(1'b1, 8'hA5, 1'b0);
        chk(buf_q == 8'hA5, "R8 idle write", int'(buf_q), 8'hA5);
        chk(wcol == 1'b0, "R8 idle write no collision", int'(wcol), 0);

        // R5 start from released bus
        do_seq(5'b00001, 0);

        // R5 transmit byte; R7 and R8 probes while busy
        issue(5'b10000, 4);
        repeat (20) @(negedge clk);
        cmd_wr = 1'b1; cmd_bits = 5'b00100;
        @(negedge clk);
        cmd_wr = 1'b0; cmd_bits = '0;
        host_pulse(1'b1, 8'h3C, 1'b0);
        chk(wcol == 1'b1, "R8 collision flagged", int'(wcol), 1);
        chk(buf_q == 8'hA5, "R8 buffer unchanged", int'(buf_q), 8'hA5);
        wait_done(4);
        repeat (6) @(negedge clk);
        chk(busy == 1'b0, "R7 no queued command", int'(busy), 0);
        chk(drv == 1'b1, "R7 line still parked low", int'(drv), 1);

        // R9 sticky flag and clear
        repeat (10) @(negedge clk);
        chk(wcol == 1'b1, "R9 flag sticky", int'(wcol), 1);
        host_pulse(1'b0, 8'h00, 1'b1);
        chk(wcol == 1'b0, "R9 flag cleared", int'(wcol), 0);

        // R4 receive byte with slave stretching
        stretch_en = 1'b1; hold_h = 20;
        issue(5'b01000, 3);
        repeat (30) @(negedge clk);
        host_pulse(1'b1, 8'h77, 1'b1);
        chk(wcol == 1'b1, "R9 set wins over clear", int'(wcol), 1);
        chk(buf_q == 8'hA5, "R8 buffer unchanged again", int'(buf_q), 8'hA5);
        wait_done(3);
        stretch_en = 1'b0;
        repeat (hold_h + 4) @(negedge clk);
        host_pulse(1'b0, 8'h00, 1'b1);
        chk(wcol == 1'b0, "R9 cleared after stretch", int'(wcol), 0);

        // R2 priority with reload zero: restart wins over stop and transmit
        n_rel = 0;
        do_seq(5'b10110, 1);

        // R2 empty request does nothing
        @(negedge clk);
        cmd_wr = 1'b1; cmd_bits = 5'b00000;
        @(negedge clk);
        cmd_wr = 1'b0;
        repeat (4) @(negedge clk);
        chk(busy == 1'b0, "R2 empty request ignored", int'(busy), 0);
        chk(drv == 1'b1, "R2 line unchanged", int'(drv), 1);

        // R5 stop, start from released, stop, with reload 5
        n_rel = 5;
        do_seq(5'b00100, 2);
        repeat (4) @(negedge clk);
        chk(drv == 1'b0, "R5 released after stop", int'(drv), 0);
        do_seq(5'b00001, 0);
        do_seq(5'b00010, 1);
        do_seq(5'b00100, 2);

        // R8 idle write after activity
        host_pulse(1'b1, 8'h5A, 1'b0);
        chk(buf_q == 8'h5A, "R8 idle write later", int'(buf_q), 8'h5A);
        repeat (5) @(negedge clk);
        chk(exp_lat.size() == 0, "R6 all sequences ended", exp_lat.size(), 0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule